// File: doc/BRIEF.md
# Thresholded Multi-Increment Event Counter

This block accumulates occurrences of one performance event. Every cycle the
event source may report zero or more occurrences (up to `MAX_INC`, six by
default) on a small count bus. A programmable threshold chooses what is added.
A threshold of zero adds the full count. A non-zero threshold turns the counter
into a counter of busy cycles: it adds one only in cycles whose count is
strictly above the threshold.

Two gates sit in front of the accumulator. The first is an instruction-set
qualifier that accepts cycles with the mode bit set, cycles with it clear, or
both. The second is a per-privilege-level enable mask. Software configures the
block through a simple write port: it can preload the counter, set the
threshold, set the qualifier and set the mask. When the counter passes its top
value it wraps to zero and raises a one-cycle overflow pulse.

The occurrence count arrives as a valid/ready stream. `occ_ready_o` is always
high and the block never applies back-pressure. A count is consumed in every
cycle in which `occ_valid_i` is high. With `occ_valid_i` low, the count bus is
ignored.

Top module: `evt_thresh_counter`

## Requirements
- R1: After reset the count is 0, the overflow pulse is low, the threshold is 0, the qualifier accepts both modes and every privilege level is enabled.
- R2: With threshold 0, each accepted cycle adds its occurrence count to the counter. The update is visible on `count_o` after the next rising edge.
- R3: With threshold n > 0, an accepted cycle adds exactly 1 when its occurrence count is strictly greater than n, and adds 0 otherwise.
- R4: A threshold write (address 1) with a value above `MAX_INC-1` stores `MAX_INC-1`. Smaller values are stored as written.
- R5: The qualifier is written at address 2, bits [1:0]. Code 1 counts only when `isa_mode_i` is 1. Code 2 counts only when it is 0. Codes 0 and 3 count in both modes.
- R6: The privilege mask is written at address 3, bits [PRIV_LVLS-1:0]. Bit p set enables counting while `priv_i` equals p. With the bit clear, counting at that level is blocked.
- R7: A cycle with `occ_valid_i` low adds nothing, whatever the count bus carries. `occ_ready_o` is always 1.
- R8: A write to address 0 loads the counter with `cfg_wdata_i[CNT_W-1:0]` at the next edge and replaces any increment from that cycle.
- R9: When an increment carries the counter past 2^CNT_W-1, the counter keeps the low CNT_W bits of the sum. `ovf_o` is high for exactly the one cycle in which the wrapped value is first shown.
- R10: A configuration write takes effect starting with the following cycle. The increment in the write cycle itself uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| occ_valid_i | input | 1 | Occurrence count valid |
| occ_ready_o | output | 1 | Always high, no back-pressure |
| occ_i | input | OCC_W (3) | Occurrences this cycle |
| isa_mode_i | input | 1 | Instruction-set mode bit |
| priv_i | input | PRIV_W (2) | Current privilege level |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | 0 counter, 1 threshold, 2 qualifier, 3 privilege mask |
| cfg_wdata_i | input | CNT_W (47) | Write data |
| count_o | output | CNT_W (47) | Counter value |
| ovf_o | output | 1 | One-cycle wrap pulse |

## Verification
Counts from 0 to 6 are driven with threshold 0 and with several non-zero thresholds. This separates plain accumulation from the strictly-greater-than comparison, and catches off-by-one errors at counts equal to the threshold. The mode bit and privilege level are swept under each qualifier code and mask pattern. This shows that each gate blocks only its own cycles. An out-of-range threshold write, a preload colliding with a live increment, invalid cycles carrying a large count, and a wrap from near the top value cover the edge behaviour. A reference model in the bench predicts each cycle's count and overflow, and these are checked against the outputs in order.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;
  typedef enum logic [1:0] {
    QUAL_ANY   = 2'd0,
    QUAL_MODE1 = 2'd1,
    QUAL_MODE0 = 2'd2,
    QUAL_ANY_B = 2'd3
  } qual_e;

  typedef enum logic [1:0] {
    CFG_COUNT = 2'd0,
    CFG_THR   = 2'd1,
    CFG_QUAL  = 2'd2,
    CFG_PRIV  = 2'd3
  } cfg_addr_e;
endpackage

// File: rtl/evtcnt_cfg.sv
module evtcnt_cfg
  import evtcnt_pkg::*;
#(
  parameter int CNT_W     = 47,
  parameter int MAX_INC   = 6,
  parameter int PRIV_LVLS = 4,
  localparam int THR_W    = (MAX_INC > 1) ? $clog2(MAX_INC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [1:0]           addr_i,
  input  logic [CNT_W-1:0]     wdata_i,
  output logic [THR_W-1:0]     thr_o,
  output qual_e                qual_o,
  output logic [PRIV_LVLS-1:0] mask_o
);
  localparam logic [CNT_W-1:0] THR_LIM = CNT_W'(MAX_INC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_o  <= '0;
      qual_o <= QUAL_ANY;
      mask_o <= '1;
    end else if (we_i) begin
      case (cfg_addr_e'(addr_i))
        CFG_THR:  thr_o  <= (wdata_i > THR_LIM) ? THR_LIM[THR_W-1:0] : wdata_i[THR_W-1:0];
        CFG_QUAL: qual_o <= qual_e'(wdata_i[1:0]);
        CFG_PRIV: mask_o <= wdata_i[PRIV_LVLS-1:0];
        default:  ;
      endcase
    end
  end

  // R4: stored threshold never leaves the legal range
  p_thr_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    thr_o <= THR_LIM[THR_W-1:0]);
endmodule

// File: rtl/evtcnt_qual.sv
module evtcnt_qual
  import evtcnt_pkg::*;
#(
  parameter int MAX_INC   = 6,
  parameter int PRIV_LVLS = 4,
  localparam int OCC_W    = $clog2(MAX_INC + 1),
  localparam int PRIV_W   = (PRIV_LVLS > 1) ? $clog2(PRIV_LVLS) : 1,
  localparam int THR_W    = (MAX_INC > 1) ? $clog2(MAX_INC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_i,
  input  logic [OCC_W-1:0]     occ_i,
  input  logic                 mode_i,
  input  logic [PRIV_W-1:0]    priv_i,
  input  logic [THR_W-1:0]     thr_i,
  input  qual_e                qual_i,
  input  logic [PRIV_LVLS-1:0] mask_i,
  output logic [OCC_W-1:0]     inc_o
);
  logic [PRIV_LVLS-1:0] lvl_hit;
  logic                 mode_ok;
  logic                 accept;

  for (genvar g = 0; g < PRIV_LVLS; g++) begin : g_lvl
    assign lvl_hit[g] = mask_i[g] && (priv_i == PRIV_W'(g));
  end

  always_comb begin
    case (qual_i)
      QUAL_MODE1: mode_ok = mode_i;
      QUAL_MODE0: mode_ok = !mode_i;
      default:    mode_ok = 1'b1;
    endcase
  end

  assign accept = valid_i && mode_ok && (|lvl_hit);

  always_comb begin
    if (!accept)
      inc_o = '0;
    else if (thr_i == '0)
      inc_o = occ_i;
    else
      inc_o = (OCC_W'(thr_i) < occ_i) ? OCC_W'(1) : '0;
  end

  // R3: threshold mode contributes at most one per cycle
  p_thr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_i != '0) |-> (inc_o <= OCC_W'(1)));
  // R7: invalid cycles contribute nothing
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> (inc_o == '0));
endmodule

// File: rtl/evtcnt_acc.sv
module evtcnt_acc #(
  parameter int CNT_W = 47,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W:0] sum;

  assign sum = {1'b0, cnt_o} + (CNT_W+1)'(inc_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else if (load_i) begin
      cnt_o <= load_val_i;
      ovf_o <= 1'b0;
    end else begin
      cnt_o <= sum[CNT_W-1:0];
      ovf_o <= sum[CNT_W];
    end
  end

  // R8: a preload wins over the increment of the same cycle
  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_o == $past(load_val_i)));
  // R9: a wrap leaves only a small residue
  p_wrap_small_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (cnt_o < CNT_W'(2**INC_W)));
  // R9: overflow is a single-cycle pulse unless a new increment wraps again
  p_ovf_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && inc_i == '0) |=> !ovf_o);
  // R7: without increment or load the counter holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && inc_i == '0) |=> $stable(cnt_o));
endmodule

// File: rtl/evt_thresh_counter.sv
module evt_thresh_counter
  import evtcnt_pkg::*;
#(
  parameter int CNT_W     = 47,
  parameter int MAX_INC   = 6,
  parameter int PRIV_LVLS = 4,
  localparam int OCC_W    = $clog2(MAX_INC + 1),
  localparam int PRIV_W   = (PRIV_LVLS > 1) ? $clog2(PRIV_LVLS) : 1,
  localparam int THR_W    = (MAX_INC > 1) ? $clog2(MAX_INC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              occ_valid_i,
  output logic              occ_ready_o,
  input  logic [OCC_W-1:0]  occ_i,
  input  logic              isa_mode_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [CNT_W-1:0]  cfg_wdata_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              ovf_o
);
  logic [THR_W-1:0]     thr;
  qual_e                qual;
  logic [PRIV_LVLS-1:0] mask;
  logic [OCC_W-1:0]     inc;
  logic                 load;

  assign occ_ready_o = 1'b1;
  assign load        = cfg_we_i && (cfg_addr_e'(cfg_addr_i) == CFG_COUNT);

  evtcnt_cfg #(.CNT_W(CNT_W), .MAX_INC(MAX_INC), .PRIV_LVLS(PRIV_LVLS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .thr_o(thr), .qual_o(qual), .mask_o(mask)
  );

  evtcnt_qual #(.MAX_INC(MAX_INC), .PRIV_LVLS(PRIV_LVLS)) u_qual (
    .clk(clk), .rst_n(rst_n), .valid_i(occ_valid_i), .occ_i(occ_i),
    .mode_i(isa_mode_i), .priv_i(priv_i), .thr_i(thr), .qual_i(qual),
    .mask_i(mask), .inc_o(inc)
  );

  evtcnt_acc #(.CNT_W(CNT_W), .INC_W(OCC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .inc_i(inc), .load_i(load),
    .load_val_i(cfg_wdata_i), .cnt_o(count_o), .ovf_o(ovf_o)
  );
endmodule

// File: tb/evt_thresh_counter_tb.sv
module evt_thresh_counter_tb;
  localparam int CNT_W = 47;
  typedef struct {
    logic [CNT_W-1:0] cnt;
    logic             ovf;
    string            req;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic occ_valid = 0, isa_mode = 0, cfg_we = 0;
  logic [2:0] occ = 0;
  logic [1:0] priv = 0, cfg_addr = 0;
  logic [CNT_W-1:0] cfg_wdata = 0;
  logic occ_ready, ovf;
  logic [CNT_W-1:0] count;

  int checks = 0, errors = 0;
  exp_t q[$];
  logic [CNT_W-1:0] m_cnt = 0;
  int m_thr = 0, m_qual = 0;
  logic [3:0] m_mask = 4'hF;
  bit running = 1;

  always #2 clk = ~clk;

  evt_thresh_counter u_dut (
    .clk(clk), .rst_n(rst_n), .occ_valid_i(occ_valid), .occ_ready_o(occ_ready),
    .occ_i(occ), .isa_mode_i(isa_mode), .priv_i(priv), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .count_o(count), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: applies one cycle and pushes the model's prediction
  task automatic cyc(input bit v, input int o, input bit md, input int pl,
                     input bit we, input int addr, input logic [CNT_W-1:0] wd,
                     input string req);
    exp_t e;
    bit mode_ok, gate;
    int inc;
    logic [CNT_W:0] s;
    @(negedge clk);
    occ_valid = v; occ = 3'(o); isa_mode = md; priv = 2'(pl);
    cfg_we = we; cfg_addr = 2'(addr); cfg_wdata = wd;
    mode_ok = (m_qual == 1) ? md : (m_qual == 2) ? !md : 1'b1;
    gate = v && mode_ok && m_mask[pl];
    inc = !gate ? 0 : (m_thr == 0) ? o : (o > m_thr ? 1 : 0);
    if (we && addr == 0) begin
      m_cnt = wd; e.ovf = 0;
    end else begin
      s = {1'b0, m_cnt} + (CNT_W+1)'(inc);
      m_cnt = s[CNT_W-1:0]; e.ovf = s[CNT_W];
    end
    if (we && addr == 1) m_thr = (wd > 5) ? 5 : int'(wd);
    if (we && addr == 2) m_qual = int'(wd[1:0]);
    if (we && addr == 3) m_mask = wd[3:0];
    e.cnt = m_cnt; e.req = req;
    q.push_back(e);
  endtask

  task automatic ev(input int o, input string req, input bit md = 0, input int pl = 0);
    cyc(1, o, md, pl, 0, 0, '0, req);
  endtask

  task automatic wr(input int addr, input logic [CNT_W-1:0] wd, input string req);
    cyc(0, 0, 0, 0, 1, addr, wd, req);
  endtask

  // monitor: pops predictions after each edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(count == e.cnt, e.req, "count", count, e.cnt);
        chk(ovf == e.ovf, e.req, "ovf", CNT_W'(ovf), CNT_W'(e.ovf));
      end
    end
  end

  initial begin
    #400000;
    if (running) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(count == 0, "R1", "count", count, 0);
    chk(ovf == 0, "R1", "ovf", CNT_W'(ovf), 0);
    chk(occ_ready == 1, "R7", "ready", CNT_W'(occ_ready), 1);
    // R2 threshold 0 accumulates all occurrences
    for (int i = 0; i <= 6; i++) ev(i, "R2");
    // R7 invalid cycles ignored
    cyc(0, 6, 0, 0, 0, 0, '0, "R7");
    cyc(0, 7, 1, 3, 0, 0, '0, "R7");
    // R3 thresholds 2 and 5, R10 write cycle uses old threshold
    cyc(1, 4, 0, 0, 1, 1, 47'd2, "R10");
    for (int i = 0; i <= 6; i++) ev(i, "R3");
    wr(1, 47'd5, "R3");
    for (int i = 4; i <= 6; i++) ev(i, "R3");
    // R4 saturating threshold write
    wr(1, 47'd100, "R4");
    ev(5, "R4"); ev(6, "R4");
    wr(1, 47'd0, "R2");
    // R5 qualifier codes
    for (int c = 0; c < 4; c++) begin
      wr(2, 47'(c), "R5");
      ev(3, "R5", 0); ev(2, "R5", 1);
    end
    wr(2, 47'd0, "R5");
    // R6 privilege mask
    wr(3, 47'b0101, "R6");
    for (int p = 0; p < 4; p++) ev(1 + p, "R6", 0, p);
    wr(3, 47'b1000, "R6");
    for (int p = 0; p < 4; p++) ev(2, "R6", 1, p);
    wr(3, 47'hF, "R6");
    // R8 preload beats increment
    cyc(1, 6, 0, 0, 1, 0, 47'd1000, "R8");
    ev(3, "R8");
    // R9 wrap and single pulse
    wr(0, {CNT_W{1'b1}} - 47'd2, "R9");
    ev(5, "R9"); ev(0, "R9"); ev(1, "R9");
    wr(0, {CNT_W{1'b1}}, "R9");
    ev(1, "R9"); cyc(0, 0, 0, 0, 0, 0, '0, "R9");
    repeat (4) @(negedge clk);
    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule